// File: doc/BRIEF.md
# I2C Transfer Direction and Address Match Tracker

This block watches an I2C bus alongside the local controller. It keeps two status flags for the controller. The first flag reports that the slave address received on the bus equals the local address. The second flag records whether the local side transmits or receives. This direction flag decides whether the local SDA driver may be enabled. The raw SCL and SDA inputs pass through a synchronizer. The block then looks for start and stop conditions and for SCL edges, and counts the clocks of each byte.

In master role, the controller reports a start it generates and the R/W bit it places on the bus. In slave role, the direction comes from the R/W bit received at the end of the first byte. Five requests clear the flags: exit from communication, wait release, the interface enable falling, a new arbitration loss, and the bus conditions listed in the requirements. When a set and a clear fall in the same cycle, the clear wins.

Top module: `i2c_dir_tracker`

## Requirements
- R1: While rst_n is low, addr_match, xmit and sda_oe are all 0.
- R2: The first byte after a start is shifted in MSB first. On the 8th rising SCL edge of that byte (the R/W bit), addr_match is set when the 7 bits received before it equal own_addr. It stays 0 on a mismatch.
- R3: addr_match is cleared by a detected start, a detected stop, exit_req, or if_enable going from 1 to 0.
- R4: With mst_mode=1, a mst_start_gen pulse sets xmit. On the 8th rising SCL edge of the first byte, xmit becomes 1 if mst_rw_bit is 0, and 0 if mst_rw_bit is 1. A detected start does not clear xmit in this role.
- R5: With mst_mode=0, on the 8th rising SCL edge of the first byte, xmit takes the received SDA bit (1 = transmit). A detected start clears xmit.
- R6: In either role, xmit is cleared by a detected stop, exit_req, wait_rel, if_enable going from 1 to 0, or arb_lost going from 0 to 1.
- R7: sda_oe is 1 only while xmit is 1 and the data phase is active. The data phase starts at the falling SCL edge that ends the 9th clock of the first byte and ends at the next start or stop.
- R8: When a clear event and a set event for the same flag happen in the same cycle, the flag ends at 0.
- R9: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. SDA changes while SCL is low are data and leave the flags unchanged. Bus inputs pass through a two-stage synchronizer, so a flag moves on the third clock edge after the bus input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| own_addr | input | 7 | Local slave address |
| mst_mode | input | 1 | 1 = local side acts as master, 0 = slave |
| mst_start_gen | input | 1 | One-cycle pulse: the master engine generates a start |
| mst_rw_bit | input | 1 | R/W bit the master places at the first byte's LSB |
| exit_req | input | 1 | Pulse: leave the current communication |
| wait_rel | input | 1 | Pulse: release the wait state |
| if_enable | input | 1 | Interface enable level |
| arb_lost | input | 1 | Arbitration-lost indication level |
| addr_match | output | 1 | Received address equals own_addr |
| xmit | output | 1 | 1 = transmit, 0 = receive |
| sda_oe | output | 1 | Enable for the local SDA driver |

## Verification
The hardest situation to reach is the combination of xmit=1 with sda_oe=1. This state needs a complete first byte and its ninth clock to finish before the wait release, the arbitration loss or the enable drop is applied. The stimulus builds whole bus transactions, using start, eight address bits, the acknowledge clock and stop. Each SCL phase is held for several clocks so that the synchronizer delay has passed. Pulses are applied only after the ninth falling edge. A repeated start in slave role and a set and clear pulse in the same cycle in master role exercise the priority rules. A queue-based model in the bench follows every clock.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;

    // Bus events, valid for one clock after the synchronizer
    typedef struct packed {
        logic start;  // SDA fell while SCL high
        logic stop;   // SDA rose while SCL high
        logic rise;   // SCL rising edge
        logic fall;   // SCL falling edge
        logic sda;    // synchronized SDA level
    } bus_ev_t;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_trk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.scl_sh = {st_q.scl_sh[SYNC_STAGES-2:0], scl_in};
        st_d.sda_sh = {st_q.sda_sh[SYNC_STAGES-2:0], sda_in};
        st_d.scl_p  = st_q.scl_sh[TOP];
        st_d.sda_p  = st_q.sda_sh[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;  // idle bus is high
        end else begin
            st_q <= st_d;
        end
    end

    logic scl_c, sda_c;
    assign scl_c = st_q.scl_sh[TOP];
    assign sda_c = st_q.sda_sh[TOP];

    always_comb begin
        ev.start = scl_c & st_q.scl_p & st_q.sda_p & ~sda_c;
        ev.stop  = scl_c & st_q.scl_p & ~st_q.sda_p & sda_c;
        ev.rise  = scl_c & ~st_q.scl_p;
        ev.fall  = ~scl_c & st_q.scl_p;
        ev.sda   = sda_c;
    end

endmodule

// File: rtl/i2c_bit_frame.sv
module i2c_bit_frame
    import i2c_trk_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int BITS_PER_BYTE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    output logic              rw_edge,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              data_phase
);

    localparam int             CNT_W  = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(BITS_PER_BYTE);
    localparam logic [CNT_W-1:0] RW_IDX = CNT_W'(BITS_PER_BYTE - 2);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              first;
        logic [ADDR_W-1:0] shift;
        logic              dph;
    } frame_st_t;

    frame_st_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (ev.start) begin
            fr_d.cnt   = '0;
            fr_d.first = 1'b1;
            fr_d.dph   = 1'b0;
        end else if (ev.stop) begin
            fr_d.first = 1'b0;
            fr_d.dph   = 1'b0;
        end else begin
            if (ev.rise) begin
                fr_d.cnt   = (fr_q.cnt == LAST) ? ONE : fr_q.cnt + ONE;
                fr_d.shift = {fr_q.shift[ADDR_W-2:0], ev.sda};
            end
            if (ev.fall && fr_q.first && fr_q.cnt == LAST) begin
                fr_d.first = 1'b0;
                fr_d.dph   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign rw_edge    = ev.rise & fr_q.first & (fr_q.cnt == RW_IDX);
    assign rx_addr    = fr_q.shift;
    assign data_phase = fr_q.dph;

endmodule

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl
    import i2c_trk_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              rw_edge,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              mst_mode,
    input  logic              mst_start_gen,
    input  logic              mst_rw_bit,
    input  logic              exit_req,
    input  logic              wait_rel,
    input  logic              if_enable,
    input  logic              arb_lost,
    output logic              addr_match,
    output logic              xmit
);

    typedef struct packed {
        logic am;
        logic tx;
        logic en_p;
        logic arb_p;
    } flag_st_t;

    flag_st_t fl_d, fl_q;
    logic en_fall, arb_rise, am_clr, tx_clr;

    always_comb begin
        en_fall  = fl_q.en_p & ~if_enable;
        arb_rise = arb_lost & ~fl_q.arb_p;
        am_clr   = ev.start | ev.stop | exit_req | en_fall;
        tx_clr   = ev.stop | exit_req | en_fall | wait_rel | arb_rise
                 | (ev.start & ~mst_mode);

        fl_d       = fl_q;
        fl_d.en_p  = if_enable;
        fl_d.arb_p = arb_lost;

        if (am_clr) begin
            fl_d.am = 1'b0;
        end else if (rw_edge && rx_addr == own_addr) begin
            fl_d.am = 1'b1;
        end

        if (tx_clr) begin
            fl_d.tx = 1'b0;
        end else if (mst_mode && mst_start_gen) begin
            fl_d.tx = 1'b1;
        end else if (rw_edge) begin
            fl_d.tx = mst_mode ? ~mst_rw_bit : ev.sda;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign addr_match = fl_q.am;
    assign xmit       = fl_q.tx;

endmodule

// File: rtl/i2c_dir_tracker.sv
module i2c_dir_tracker
    import i2c_trk_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int SYNC_STAGES   = 2,
    parameter int BITS_PER_BYTE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              mst_mode,
    input  logic              mst_start_gen,
    input  logic              mst_rw_bit,
    input  logic              exit_req,
    input  logic              wait_rel,
    input  logic              if_enable,
    input  logic              arb_lost,
    output logic              addr_match,
    output logic              xmit,
    output logic              sda_oe
);

    bus_ev_t           bus_ev;
    logic              rw_edge;
    logic [ADDR_W-1:0] rx_addr;
    logic              data_phase;
    logic              stop_seen;

    i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev)
    );

    i2c_bit_frame #(.ADDR_W(ADDR_W), .BITS_PER_BYTE(BITS_PER_BYTE)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (bus_ev),
        .rw_edge    (rw_edge),
        .rx_addr    (rx_addr),
        .data_phase (data_phase)
    );

    i2c_flag_ctrl #(.ADDR_W(ADDR_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (bus_ev),
        .rw_edge       (rw_edge),
        .rx_addr       (rx_addr),
        .own_addr      (own_addr),
        .mst_mode      (mst_mode),
        .mst_start_gen (mst_start_gen),
        .mst_rw_bit    (mst_rw_bit),
        .exit_req      (exit_req),
        .wait_rel      (wait_rel),
        .if_enable     (if_enable),
        .arb_lost      (arb_lost),
        .addr_match    (addr_match),
        .xmit          (xmit)
    );

    assign sda_oe    = xmit & data_phase;
    assign stop_seen = bus_ev.stop;

endmodule

// File: rtl/i2c_dir_tracker_chk.sv
module i2c_dir_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_evt,
    input logic mst_mode,
    input logic mst_start_gen,
    input logic exit_req,
    input logic wait_rel,
    input logic if_enable,
    input logic arb_lost,
    input logic addr_match,
    input logic xmit,
    input logic sda_oe
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!addr_match && !xmit && !sda_oe);
        end
    end

    // R3
    exit_clears_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !addr_match);

    // R3
    enable_drop_clears_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_enable && $past(if_enable)) |=> !addr_match);

    // R6
    wait_release_clears_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_rel |=> !xmit);

    // R6
    arb_loss_clears_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |=> !xmit);

    // R4
    start_gen_sets_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_mode && mst_start_gen && !exit_req && !wait_rel && !stop_evt
         && !$rose(arb_lost) && !$fell(if_enable)) |=> xmit);

    // R8
    clear_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_mode && mst_start_gen && exit_req) |=> !xmit);

endmodule

bind i2c_dir_tracker i2c_dir_tracker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_evt      (stop_seen),
    .mst_mode      (mst_mode),
    .mst_start_gen (mst_start_gen),
    .exit_req      (exit_req),
    .wait_rel      (wait_rel),
    .if_enable     (if_enable),
    .arb_lost      (arb_lost),
    .addr_match    (addr_match),
    .xmit          (xmit),
    .sda_oe        (sda_oe)
);

// File: tb/i2c_dir_tracker_bench.sv
`timescale 1ns/1ps
module i2c_dir_tracker_bench;

    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic [6:0] own_addr = OWN;
    logic mst_mode = 1'b0, mst_start_gen = 1'b0, mst_rw_bit = 1'b0;
    logic exit_req = 1'b0, wait_rel = 1'b0, if_enable = 1'b1, arb_lost = 1'b0;
    logic addr_match, xmit, sda_oe;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_dir_tracker u_i2c_dir_tracker (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .own_addr(own_addr), .mst_mode(mst_mode), .mst_start_gen(mst_start_gen),
        .mst_rw_bit(mst_rw_bit), .exit_req(exit_req), .wait_rel(wait_rel),
        .if_enable(if_enable), .arb_lost(arb_lost),
        .addr_match(addr_match), .xmit(xmit), .sda_oe(sda_oe)
    );

    // ---------------- reference model ----------------
    logic [1:0] hist[$];
    int   m_cnt;
    bit   m_first, m_am, m_tx, m_dp, m_en, m_arb;
    logic [6:0] m_shift;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 4; i++) hist.push_back(2'b11);
            m_cnt = 0; m_first = 0; m_am = 0; m_tx = 0; m_dp = 0;
            m_en = 0; m_arb = 0; m_shift = '0;
        end else begin
            bit ps, pd, cs, cd, st, sp, ri, fa, rw8, en_f, arb_r, clr_a, clr_t;
            hist.push_back({scl_in, sda_in});
            void'(hist.pop_front());
            {ps, pd} = hist[0];
            {cs, cd} = hist[1];
            st = ps && cs && pd && !cd;
            sp = ps && cs && !pd && cd;
            ri = cs && !ps;
            fa = !cs && ps;
            rw8   = ri && m_first && (m_cnt == 7);
            en_f  = m_en && !if_enable;
            arb_r = arb_lost && !m_arb;
            clr_a = st || sp || exit_req || en_f;
            clr_t = sp || exit_req || en_f || wait_rel || arb_r || (st && !mst_mode);
            if (clr_a) m_am = 0;
            else if (rw8 && m_shift == own_addr) m_am = 1;
            if (clr_t) m_tx = 0;
            else if (mst_mode && mst_start_gen) m_tx = 1;
            else if (rw8) m_tx = mst_mode ? !mst_rw_bit : cd;
            if (st) begin
                m_cnt = 0; m_first = 1; m_dp = 0;
            end else if (sp) begin
                m_first = 0; m_dp = 0;
            end else begin
                bit was_last;
                was_last = (m_cnt == 9);
                if (fa && m_first && was_last) begin
                    m_first = 0; m_dp = 1;
                end
                if (ri) begin
                    m_cnt   = was_last ? 1 : m_cnt + 1;
                    m_shift = {m_shift[5:0], cd};
                end
            end
            m_en  = if_enable;
            m_arb = arb_lost;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R2/R3 addr_match vs model", addr_match, m_am);
            chk("R4/R5/R6/R8 xmit vs model", xmit, m_tx);
            chk("R7 sda_oe vs model", sda_oe, m_tx & m_dp);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input logic c, input logic d);
        scl_in = c; sda_in = d; tick(4);
    endtask

    task automatic send_start;
        bus(1, 1); bus(1, 0); bus(0, 0);
    endtask

    task automatic send_stop;
        bus(0, 0); bus(1, 0); bus(1, 1);
    endtask

    task automatic send_bit(input logic b);
        bus(0, b); bus(1, b); bus(0, b);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // 0 start_gen, 1 exit, 2 wait, 3 start_gen+exit
    task automatic pulse(input int which);
        case (which)
            0: mst_start_gen = 1;
            1: exit_req = 1;
            2: wait_rel = 1;
            default: begin mst_start_gen = 1; exit_req = 1; end
        endcase
        tick(1);
        mst_start_gen = 0; exit_req = 0; wait_rel = 0;
        tick(2);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 addr_match in reset", addr_match, 1'b0);
        chk("R1 xmit in reset", xmit, 1'b0);
        chk("R1 sda_oe in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        tick(4);

        // slave write, address match
        send_start;
        send_byte({OWN, 1'b0});
        chk("R2 match on own address", addr_match, 1'b1);
        chk("R5 slave write gives receive", xmit, 1'b0);
        send_bit(1'b0);
        chk("R7 no drive while receiving", sda_oe, 1'b0);
        send_stop;
        chk("R3 stop clears match", addr_match, 1'b0);

        // slave read, drive after ninth clock, wait release
        send_start;
        send_byte({OWN, 1'b1});
        chk("R5 slave read gives transmit", xmit, 1'b1);
        chk("R7 no drive before ninth fall", sda_oe, 1'b0);
        send_bit(1'b0);
        chk("R7 drive after ninth fall", sda_oe, 1'b1);
        bus(0, 1); bus(0, 0);
        chk("R9 SDA change with SCL low keeps match", addr_match, 1'b1);
        chk("R9 SDA change with SCL low keeps xmit", xmit, 1'b1);
        pulse(2);
        chk("R6 wait release clears xmit", xmit, 1'b0);
        chk("R7 wait release releases SDA", sda_oe, 1'b0);

        // repeated start in slave role
        send_start;
        send_byte({OWN, 1'b1});
        send_bit(1'b0);
        chk("R5 transmit before repeated start", xmit, 1'b1);
        send_start;
        chk("R5 repeated start clears xmit", xmit, 1'b0);
        chk("R3 repeated start clears match", addr_match, 1'b0);

        // mismatch
        send_byte({7'h11, 1'b1});
        chk("R2 no match on other address", addr_match, 1'b0);
        send_bit(1'b1);
        send_stop;
        chk("R6 stop clears xmit", xmit, 1'b0);

        // master write with arbitration loss
        mst_mode = 1'b1; mst_rw_bit = 1'b0;
        pulse(0);
        chk("R4 start generate sets xmit", xmit, 1'b1);
        send_start;
        chk("R4 detected start keeps master xmit", xmit, 1'b1);
        send_byte({7'h22, 1'b0});
        send_bit(1'b0);
        chk("R4 master write stays transmit", xmit, 1'b1);
        chk("R7 master drive after ninth fall", sda_oe, 1'b1);
        arb_lost = 1'b1; tick(3);
        chk("R6 arbitration loss clears xmit", xmit, 1'b0);
        arb_lost = 1'b0; tick(2);
        send_stop;

        // master read
        mst_rw_bit = 1'b1;
        pulse(0);
        send_start;
        send_byte({7'h22, 1'b1});
        chk("R4 master read gives receive", xmit, 1'b0);
        send_bit(1'b0);
        send_stop;

        // priority and exit
        pulse(3);
        chk("R8 clear wins over start generate", xmit, 1'b0);
        pulse(0);
        chk("R4 start generate sets xmit again", xmit, 1'b1);
        pulse(1);
        chk("R6 exit clears xmit", xmit, 1'b0);

        // exit and enable drop clear match
        mst_mode = 1'b0;
        send_start;
        send_byte({OWN, 1'b0});
        chk("R2 match before exit", addr_match, 1'b1);
        pulse(1);
        chk("R3 exit clears match", addr_match, 1'b0);
        send_stop;
        send_start;
        send_byte({OWN, 1'b1});
        chk("R2 match before enable drop", addr_match, 1'b1);
        chk("R5 transmit before enable drop", xmit, 1'b1);
        if_enable = 1'b0; tick(3);
        chk("R3 enable drop clears match", addr_match, 1'b0);
        chk("R6 enable drop clears xmit", xmit, 1'b0);
        if_enable = 1'b1; tick(2);
        send_bit(1'b1);
        send_stop;
        tick(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule